// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block produces a programmable periodic event from a 32768 Hz time base. The time base arrives as a single-cycle tick strobe in the system clock domain. A 4-bit rate code selects how many ticks make up one period. On each expiry the block emits a one-cycle periodic-flag pulse. The matching interrupt-request pulse comes with it whenever the periodic interrupt enable is set. A status register elsewhere in the chip latches both pulses.

Counting runs only while three things hold: the rate code is non-zero, the enable is set, and the divider-control field allows the oscillator chain to run. Any change to the rate code or the enable restarts counting from zero, and so does dropping out of the running state. The first event after a restart always comes one full new period later.

Top module: `periodic_rate_gen`

## Requirements
- R1: While reset is asserted, and after it until the first expiry, `pf_pulse` and `irq_pulse` are 0.
- R2: For rate code n in 3..15, the number of tick strobes from a restart to the first `pf_pulse`, and between consecutive pulses, is 2^(n-1).
- R3: Rate code 1 gives a period of 128 ticks and rate code 2 gives 256 ticks.
- R4: With rate code 0, no `pf_pulse` or `irq_pulse` is produced.
- R5: With `rate_ie` at 0, no `pf_pulse` or `irq_pulse` is produced.
- R6: The counter runs only when `div_ctrl` is 3'b010 or less. Any larger value (for example 3'b011 or 3'b110) holds it at zero and suppresses all pulses.
- R7: `pf_pulse` is high for exactly one clock cycle per expiry.
- R8: `irq_pulse` is high only in a cycle where `pf_pulse` is high, and only while `rate_ie` is 1.
- R9: A change of rate code restarts the count. The first pulse after the change comes after one full new period of ticks, whatever part of the old period had elapsed.
- R10: Only clock edges with `tick_en` high advance the count. The pulse interval is measured in tick strobes, not in clock cycles.
- R11: When the block enters the running state (the enable is set, or the divider is released to 3'b010 or less), the first pulse comes after one full period of ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle strobe at 32768 Hz |
| rate_code | input | 4 | Period select code |
| rate_ie | input | 1 | Periodic interrupt enable |
| div_ctrl | input | 3 | Divider control field; 3'b010 or less runs the chain |
| pf_pulse | output | 1 | Periodic flag set pulse |
| irq_pulse | output | 1 | Interrupt request set pulse |

## Verification
The only internal state is the tick counter and the two registers that hold the previous rate code and enable. A wrong counter value or a missed restart therefore shows as a pulse that is too early or too late, in the very first period after a configuration change. The sweep covers every rate code and measures the first and second intervals in ticks. It also changes the code mid-period, in both directions, to catch a restart that fails to fire. Sparse tick patterns separate tick counting from cycle counting. The hold conditions are each watched for longer than a full period.

// File: rtl/periodic_rate_gen.sv
`timescale 1ns/1ps
module periodic_rate_gen #(
  parameter int RATE_W      = 4,
  parameter int DIV_W       = 3,
  parameter int DIV_RUN_MAX = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [RATE_W-1:0] rate_code,
  input  logic              rate_ie,
  input  logic [DIV_W-1:0]  div_ctrl,
  output logic              pf_pulse,
  output logic              irq_pulse
);
  localparam int CNT_W = (1 << RATE_W) - 2;
  localparam int SH_W  = RATE_W + 1;

  logic [RATE_W-1:0] code_q;
  logic              ie_q;
  logic [CNT_W-1:0]  cnt;
  logic [SH_W-1:0]   shift;
  logic [CNT_W:0]    span;
  logic [CNT_W-1:0]  last;
  logic              running, restart, expire;

  // codes 1 and 2 alias onto the 128 and 256 tick periods
  assign shift   = (rate_code < RATE_W'(3)) ? SH_W'(rate_code) + SH_W'(6)
                                            : SH_W'(rate_code) - SH_W'(1);
  assign span    = (CNT_W+1)'(1) << shift;
  assign last    = CNT_W'(span - (CNT_W+1)'(1));
  assign running = rate_ie && (rate_code != '0) && (div_ctrl <= DIV_W'(DIV_RUN_MAX));
  assign restart = !running || (rate_code != code_q) || (rate_ie != ie_q);
  assign expire  = tick_en && (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_q    <= '0;
      ie_q      <= 1'b0;
      cnt       <= '0;
      pf_pulse  <= 1'b0;
      irq_pulse <= 1'b0;
    end else begin
      code_q <= rate_code;
      ie_q   <= rate_ie;
      if (restart) begin
        cnt       <= '0;
        pf_pulse  <= 1'b0;
        irq_pulse <= 1'b0;
      end else begin
        if (tick_en) cnt <= expire ? '0 : cnt + CNT_W'(1);
        pf_pulse  <= expire;
        irq_pulse <= expire && rate_ie;
      end
    end
  end
endmodule

// File: rtl/periodic_rate_gen_chk.sv
`timescale 1ns/1ps
module periodic_rate_gen_chk #(
  parameter int RATE_W      = 4,
  parameter int DIV_W       = 3,
  parameter int DIV_RUN_MAX = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [RATE_W-1:0] rate_code,
  input logic              rate_ie,
  input logic [DIV_W-1:0]  div_ctrl,
  input logic              pf_pulse,
  input logic              irq_pulse
);
  assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pf_pulse |=> !pf_pulse);
  assert_irq_qualified_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (pf_pulse && rate_ie));
  assert_code_zero_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |=> (!pf_pulse && !irq_pulse));
  assert_disabled_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rate_ie |=> (!pf_pulse && !irq_pulse));
  assert_divider_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (div_ctrl > DIV_W'(DIV_RUN_MAX)) |=> !pf_pulse);
  assert_tick_driven_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_pulse && !$stable(pf_pulse)) |-> $past(tick_en));
  assert_rate_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code != $past(rate_code)) |=> !pf_pulse);
endmodule

bind periodic_rate_gen periodic_rate_gen_chk #(
  .RATE_W(RATE_W), .DIV_W(DIV_W), .DIV_RUN_MAX(DIV_RUN_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_code(rate_code),
  .rate_ie(rate_ie), .div_ctrl(div_ctrl), .pf_pulse(pf_pulse), .irq_pulse(irq_pulse)
);

// File: tb/periodic_rate_gen_bench.sv
`timescale 1ns/1ps
module periodic_rate_gen_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic       rate_ie = 1'b0;
  logic [2:0] div_ctrl = 3'd2;
  logic       pf_pulse, irq_pulse;
  int checks = 0;
  int fails = 0;
  int wd = 0;

  always #2.5 clk = ~clk;

  periodic_rate_gen u_periodic_rate_gen (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rate_code(rate_code),
    .rate_ie(rate_ie), .div_ctrl(div_ctrl), .pf_pulse(pf_pulse), .irq_pulse(irq_pulse)
  );

  always @(posedge clk) begin
    wd++;
    if (wd == 190000) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=%0d cycles expected<190000", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int period_of(input int c);
    if (c == 1) return 128;
    if (c == 2) return 256;
    return 1 << (c - 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_cfg(input int code, input int gap, input int nev, input string req);
    int exp, ticks, seen, limit;
    exp = period_of(code);
    ticks = 0;
    seen = 0;
    @(negedge clk);
    rate_code = 4'(code);
    rate_ie = 1'b1;
    div_ctrl = 3'd2;
    tick_en = 1'b0;
    @(negedge clk);
    limit = exp * gap * nev + 10;
    for (int i = 0; i < limit && seen < nev; i++) begin
      tick_en = ((i % gap) == 0);
      @(negedge clk);
      if (tick_en) ticks++;
      if (pf_pulse) begin
        check(ticks == exp, req, ticks, exp);
        check(irq_pulse == 1'b1, "R8 irq with flag", int'(irq_pulse), 1);
        seen++;
        ticks = 0;
      end else if (irq_pulse) begin
        check(1'b0, "R8 irq without flag", 1, 0);
      end
    end
    tick_en = 1'b0;
    check(seen == nev, req, seen, nev);
  endtask

  task automatic quiet(input int code, input bit ie, input logic [2:0] dv, input int n,
                       input string req);
    int hits;
    hits = 0;
    @(negedge clk);
    rate_code = 4'(code);
    rate_ie = ie;
    div_ctrl = dv;
    for (int i = 0; i < n; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      if (pf_pulse || irq_pulse) hits++;
    end
    tick_en = 1'b0;
    check(hits == 0, req, hits, 0);
  endtask

  task automatic partial(input int code, input int nt, input string req);
    int hits;
    hits = 0;
    @(negedge clk);
    rate_code = 4'(code);
    rate_ie = 1'b1;
    div_ctrl = 3'd2;
    tick_en = 1'b0;
    for (int i = 0; i < nt; i++) begin
      tick_en = 1'b1;
      @(negedge clk);
      if (pf_pulse) hits++;
    end
    tick_en = 1'b0;
    check(hits == 0, req, hits, 0);
  endtask

  initial begin
    rate_code = 4'd3;
    rate_ie = 1'b1;
    tick_en = 1'b1;
    repeat (4) @(negedge clk);
    check(pf_pulse == 1'b0 && irq_pulse == 1'b0, "R1 reset outputs", int'(pf_pulse), 0);
    rst_n = 1'b1;
    tick_en = 1'b0;
    @(negedge clk);
    check(pf_pulse == 1'b0 && irq_pulse == 1'b0, "R1 after reset", int'(pf_pulse), 0);

    // R2 / R3: every code, two intervals each
    for (int c = 15; c >= 1; c--) begin
      if (c <= 2) run_cfg(c, 1, 2, "R3 aliased period");
      else        run_cfg(c, 1, 2, "R2 period");
    end

    // R10: sparse tick strobes
    run_cfg(4, 3, 2, "R10 tick-counted period");
    run_cfg(3, 5, 2, "R10 tick-counted period");

    // R4 / R5 / R6 hold conditions
    quiet(0, 1'b1, 3'd2, 300, "R4 code zero idle");
    quiet(3, 1'b0, 3'd2, 60, "R5 disabled idle");
    run_cfg(3, 1, 1, "R11 first period after enable");
    quiet(3, 1'b1, 3'b110, 60, "R6 divider reset hold");
    run_cfg(3, 1, 1, "R11 first period after divider release");
    quiet(3, 1'b1, 3'b011, 60, "R6 divider 011 hold");
    quiet(3, 1'b1, 3'b111, 60, "R6 divider 111 hold");
    run_cfg(3, 1, 1, "R11 first period after divider release");

    // R9: mid-period rate changes in both directions
    partial(5, 10, "R9 no pulse before change");
    run_cfg(4, 1, 1, "R9 shorter period restart");
    partial(4, 6, "R9 no pulse before change");
    run_cfg(6, 1, 1, "R9 longer period restart");
    partial(6, 31, "R9 no pulse before change");
    run_cfg(5, 1, 2, "R9 restart near expiry");

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule